// File: doc/BRIEF.md
# DMA Ready Handshake Generator

This block turns the fill state of a receive buffer and a transmit buffer into two active-low DMA request lines, one per direction. A DMA controller watches the lines and moves characters while its line is low. Two signalling styles are offered. The single-transfer style asks for service on each character. The multi-transfer style keeps the request active for a burst. A receive burst runs until the buffer is drained, and a transmit burst runs until the buffer is full.

The style is chosen by a mode bit, but that bit only applies while FIFO operation is enabled. With FIFO operation off, the single-transfer style is always used. The receive side reacts to its buffer level and to two flags raised elsewhere: threshold reached and idle timeout. The transmit side reacts to its buffer level alone.

Each direction is a two-state machine:
- `ST_IDLE` means the request is inactive and the line is high.
- `ST_REQ` means the request is active and the line is low.

The transitions are:
- Receive, `RX_GRANT` (ST_IDLE to ST_REQ): the buffer is not empty, and either the single-transfer style is in effect or the threshold or timeout flag is high.
- Receive, `RX_DRAINED` (ST_REQ to ST_IDLE): the buffer is empty.
- Transmit, `TX_STARVED` (ST_IDLE to ST_REQ): the buffer is empty.
- Transmit, `TX_SATISFIED` (ST_REQ to ST_IDLE): in the single-transfer style the buffer is no longer empty, or in the multi-transfer style the buffer is completely full.

Every other case holds the current state. The state registers update on the rising clock edge, so an output reflects the inputs seen at the previous edge.

Top module: `dma_ready_gen`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, both `rx_req_n` and `tx_req_n` are high.
- R2: When `fifo_en` is 0, both directions follow the single-transfer rules whatever `multi_xfer` holds. The multi-transfer style is in effect only when `fifo_en` and `multi_xfer` are both 1.
- R3: In the single-transfer style, `rx_req_n` is low in the cycle after an edge that sees `rx_level` nonzero, and high in the cycle after an edge that sees `rx_level` equal to 0.
- R4: In the multi-transfer style, an idle receive request goes low one cycle after an edge that sees a nonzero `rx_level` together with `rx_trig_hit` or `rx_idle_tmo` high.
- R5: In the multi-transfer style, a low `rx_req_n` stays low while `rx_level` is nonzero, even after both flags fall. It goes high one cycle after an edge that sees `rx_level` equal to 0.
- R6: In the multi-transfer style, an idle receive request stays high while both flags are low, at any nonzero level.
- R7: In the single-transfer style, `tx_req_n` is low in the cycle after an edge that sees `tx_level` equal to 0, and high in the cycle after an edge that sees `tx_level` nonzero.
- R8: In the multi-transfer style, `tx_req_n` goes low one cycle after an edge that sees `tx_level` equal to 0.
- R9: In the multi-transfer style, a low `tx_req_n` stays low while `tx_level` is between 1 and DEPTH-1.
- R10: In the multi-transfer style, `tx_req_n` goes high one cycle after an edge that sees `tx_level` equal to DEPTH (16 by default). It stays high until the level returns to 0.
- R11: In the multi-transfer style, a threshold or timeout flag that arrives while `rx_level` is 0 leaves `rx_req_n` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fifo_en | input | 1 | FIFO operation enabled; when 0, the single-transfer style is forced |
| multi_xfer | input | 1 | 1 selects the multi-transfer style (effective only with fifo_en) |
| rx_level | input | CW | Characters held in the receive buffer, 0..DEPTH |
| rx_trig_hit | input | 1 | Receive threshold reached |
| rx_idle_tmo | input | 1 | Receive idle timeout occurred |
| tx_level | input | CW | Characters held in the transmit buffer, 0..DEPTH |
| rx_req_n | output | 1 | Receive DMA request, active low |
| tx_req_n | output | 1 | Transmit DMA request, active low |

## Verification
The assertions assume that both level inputs never exceed DEPTH, and that every input is stable around the rising clock edge. This lets empty and full be read directly from the levels. The stimulus draws levels only from 0 to DEPTH and drives all inputs on the falling edge. The random level distribution is weighted toward exactly 0 and exactly DEPTH, so the boundary transitions occur often. The threshold and timeout flags are allowed to rise even at level 0, so that the empty-wins case is exercised.

// File: rtl/dma_rdy_pkg.sv
package dma_rdy_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_REQ  = 1'b1
    } req_state_e;

endpackage

// File: rtl/dma_mode_sel.sv
module dma_mode_sel (
    input  logic fifo_en,
    input  logic multi_xfer,
    output logic multi_eff
);
    // Multi-transfer signalling exists only with FIFO operation on.
    always_comb begin
        multi_eff = fifo_en & multi_xfer;
    end
endmodule

// File: rtl/dma_level_flags.sv
module dma_level_flags #(
    parameter int DEPTH = 16,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic [CW-1:0] level,
    output logic          is_empty,
    output logic          is_full
);
    localparam logic [CW-1:0] FULL_VAL = CW'(DEPTH);

    always_comb begin
        is_empty = (level == '0);
        is_full  = (level == FULL_VAL);
    end
endmodule

// File: rtl/dma_rx_fsm.sv
module dma_rx_fsm
    import dma_rdy_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic multi_eff,
    input  logic buf_empty,
    input  logic trig_hit,
    input  logic idle_tmo,
    output logic req_n
);
    req_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                // RX_GRANT
                if (!buf_empty && (!multi_eff || trig_hit || idle_tmo))
                    state_d = ST_REQ;
            end
            ST_REQ: begin
                // RX_DRAINED
                if (buf_empty)
                    state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        req_n = (state_q != ST_REQ);
    end

    AST_RX_SINGLE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (!multi_eff && !buf_empty) |=> !req_n); // R3
    AST_RX_EMPTY_REL: assert property (@(posedge clk) disable iff (!rst_n)
        buf_empty |=> req_n); // R5
    AST_RX_BURST_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (multi_eff && !buf_empty && (trig_hit || idle_tmo)) |=> !req_n); // R4
    AST_RX_BURST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (multi_eff && !req_n && !buf_empty) |=> !req_n); // R5
    AST_RX_NO_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (multi_eff && req_n && !trig_hit && !idle_tmo) |=> req_n); // R6
endmodule

// File: rtl/dma_tx_fsm.sv
module dma_tx_fsm
    import dma_rdy_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic multi_eff,
    input  logic buf_empty,
    input  logic buf_full,
    output logic req_n
);
    req_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                // TX_STARVED
                if (buf_empty)
                    state_d = ST_REQ;
            end
            ST_REQ: begin
                // TX_SATISFIED
                if ((!multi_eff && !buf_empty) || buf_full)
                    state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        req_n = (state_q != ST_REQ);
    end

    AST_TX_EMPTY_SET: assert property (@(posedge clk) disable iff (!rst_n)
        buf_empty |=> !req_n); // R8
    AST_TX_SINGLE_REL: assert property (@(posedge clk) disable iff (!rst_n)
        (!multi_eff && !buf_empty) |=> req_n); // R7
    AST_TX_BURST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (multi_eff && !req_n && !buf_full) |=> !req_n); // R9
    AST_TX_FULL_REL: assert property (@(posedge clk) disable iff (!rst_n)
        buf_full |=> req_n); // R10
    AST_TX_BURST_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (multi_eff && req_n && !buf_empty) |=> req_n); // R10
endmodule

// File: rtl/dma_ready_gen.sv
module dma_ready_gen #(
    parameter int DEPTH = 16,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fifo_en,
    input  logic          multi_xfer,
    input  logic [CW-1:0] rx_level,
    input  logic          rx_trig_hit,
    input  logic          rx_idle_tmo,
    input  logic [CW-1:0] tx_level,
    output logic          rx_req_n,
    output logic          tx_req_n
);
    logic multi_eff;
    logic rx_empty, rx_full_unused;
    logic tx_empty, tx_full;

    dma_mode_sel u_mode (
        .fifo_en    (fifo_en),
        .multi_xfer (multi_xfer),
        .multi_eff  (multi_eff)
    );

    dma_level_flags #(.DEPTH(DEPTH)) u_rx_flags (
        .level    (rx_level),
        .is_empty (rx_empty),
        .is_full  (rx_full_unused)
    );

    dma_level_flags #(.DEPTH(DEPTH)) u_tx_flags (
        .level    (tx_level),
        .is_empty (tx_empty),
        .is_full  (tx_full)
    );

    dma_rx_fsm u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .multi_eff (multi_eff),
        .buf_empty (rx_empty),
        .trig_hit  (rx_trig_hit),
        .idle_tmo  (rx_idle_tmo),
        .req_n     (rx_req_n)
    );

    dma_tx_fsm u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .multi_eff (multi_eff),
        .buf_empty (tx_empty),
        .buf_full  (tx_full),
        .req_n     (tx_req_n)
    );

    AST_RX_FORCED_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_en && rx_level != '0) |=> !rx_req_n); // R2
    AST_TX_FORCED_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_en && tx_level != '0) |=> tx_req_n); // R2
    AST_RX_EMPTY_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_level == '0) |=> rx_req_n); // R11
    AST_LEVEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_level <= CW'(DEPTH)) && (tx_level <= CW'(DEPTH)));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            AST_RESET_IDLE: assert (rx_req_n && tx_req_n); // R1
        end
    end
endmodule

// File: tb/sim_dma_ready_gen.sv
module sim_dma_ready_gen;
    localparam int DEPTH = 16;
    localparam int CW = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fifo_en = 1'b0, multi_xfer = 1'b0;
    logic [CW-1:0] rx_level = '0, tx_level = '0;
    logic rx_trig_hit = 1'b0, rx_idle_tmo = 1'b0;
    logic rx_req_n, tx_req_n;

    int n_cmp = 0, n_bad = 0;
    logic rx_act = 1'b0, tx_act = 1'b0;  // model: 1 = request active
    logic done = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    dma_ready_gen #(.DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .multi_xfer(multi_xfer),
        .rx_level(rx_level), .rx_trig_hit(rx_trig_hit), .rx_idle_tmo(rx_idle_tmo),
        .tx_level(tx_level), .rx_req_n(rx_req_n), .tx_req_n(tx_req_n)
    );

    function automatic logic rx_model(logic cur, logic m1, int lvl, logic trg, logic tmo);
        if (lvl == 0) return 1'b0;
        if (!m1) return 1'b1;
        return cur | trg | tmo;
    endfunction

    function automatic logic tx_model(logic cur, logic m1, int lvl);
        if (lvl == 0) return 1'b1;
        if (!m1) return 1'b0;
        if (lvl == DEPTH) return 1'b0;
        return cur;
    endfunction

    task automatic chk(string tag, string nm, logic act, logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%b expected=%b t=%0t", tag, nm, act, exp, $time);
        end
    endtask

    // Called just after a falling edge: drive, let one rising edge pass, check.
    task automatic step(logic fe, logic mm, int rl, logic trg, logic tmo, int tl,
                        string rtag, string ttag);
        logic m1;
        fifo_en = fe; multi_xfer = mm;
        rx_level = CW'(rl); rx_trig_hit = trg; rx_idle_tmo = tmo;
        tx_level = CW'(tl);
        m1 = fe & mm;
        rx_act = rx_model(rx_act, m1, rl, trg, tmo);
        tx_act = tx_model(tx_act, m1, tl);
        @(negedge clk);
        chk(rtag, "rx_req_n", rx_req_n, ~rx_act);
        chk(ttag, "tx_req_n", tx_req_n, ~tx_act);
    endtask

    function automatic int pick_level();
        int r = $urandom_range(0, 9);
        if (r < 2) return 0;
        if (r < 4) return DEPTH;
        return $urandom_range(1, DEPTH - 1);
    endfunction

    initial begin
        void'($urandom(32'd7531));
        repeat (3) @(negedge clk);
        chk("R1", "rx_req_n", rx_req_n, 1'b1);
        chk("R1", "tx_req_n", tx_req_n, 1'b1);
        rst_n = 1'b1;  // tx_level = 0 here, so tx requests after the next edge
        chk("R1", "rx_req_n", rx_req_n, 1'b1);
        chk("R1", "tx_req_n", tx_req_n, 1'b1);

        // R2: mode bit ignored with FIFO off
        step(0, 1, 3, 0, 0, 0, "R2", "R2");
        step(0, 1, 3, 0, 0, 1, "R2", "R2");
        step(0, 1, 0, 0, 0, 1, "R3", "R7");
        step(0, 0, 1, 0, 0, 0, "R3", "R7");
        step(0, 0, 1, 0, 0, 4, "R3", "R7");

        // receive multi-transfer
        step(1, 1, 0, 0, 0, 4, "R3", "R9");
        step(1, 1, 5, 0, 0, 4, "R6", "R10");
        step(1, 1, 9, 0, 0, 4, "R6", "R10");
        step(1, 1, 9, 1, 0, 4, "R4", "R10");
        step(1, 1, 2, 0, 0, 4, "R5", "R10");
        step(1, 1, 1, 0, 0, 4, "R5", "R10");
        step(1, 1, 0, 0, 0, 4, "R5", "R10");
        step(1, 1, 0, 1, 1, 4, "R11", "R10");
        step(1, 1, 3, 0, 1, 4, "R4", "R10");
        step(1, 1, 0, 0, 0, 4, "R5", "R10");

        // transmit multi-transfer
        step(1, 1, 0, 0, 0, 0, "R11", "R8");
        for (int k = 1; k < DEPTH; k++)
            step(1, 1, 0, 0, 0, k, "R11", "R9");
        step(1, 1, 0, 0, 0, DEPTH, "R11", "R10");
        step(1, 1, 0, 0, 0, 8, "R11", "R10");
        step(1, 1, 0, 0, 0, 0, "R11", "R8");

        // random mix
        for (int i = 0; i < 4000; i++) begin
            logic fe = ($urandom_range(0, 3) != 0);
            logic mm = ($urandom_range(0, 3) != 0);
            logic trg = ($urandom_range(0, 7) == 0);
            logic tmo = ($urandom_range(0, 11) == 0);
            step(fe, mm, pick_level(), trg, tmo, pick_level(),
                 (fe & mm) ? "R4" : "R3", (fe & mm) ? "R9" : "R7");
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule